// File: doc/BRIEF.md
# Segmented Ring-Buffer Stream Capture

This block takes a 32-bit stream from a producer and stores it in an on-chip ring of equal-sized segments. A segment closes when the producer marks a beat as the end of a packet, or when the segment is full, whichever comes first. Writing then continues in the next segment of the ring. A consumer drains the captured data with a periodic step pulse. Each step releases every closed segment and replays their words, oldest first, as a burst of exactly `XFER_WORDS` beats.

If the closed segments hold fewer words than the burst length, the burst is padded with zeros. If they hold more, the surplus words are released but not sent. The segment still being written is never released, so its words wait for a later step. Along with the last beat, a count reports how many valid words the step drained.

If the producer closes a segment while every other segment is still unread, the oldest unread segment is dropped and a sticky overflow flag is raised. A step pulse that arrives during a burst is ignored and sets a sticky error flag.

Top module: `seg_ring_capture`

## Requirements
- R1: While `rst` is high, `sTready` is 0. After reset, `mTvalid`, `mTlast`, `wordCountValid`, `wordCount`, `overflowFlag` and `stepErrFlag` are all 0.
- R2: When a beat with `sTlast`=1 is accepted, its segment closes. `sTready` is 0 for exactly the one following cycle and then returns to 1.
- R3: When a beat is accepted that fills a segment to `SEG_DEPTH` words, the segment closes even if `sTlast`=0. This causes the same single-cycle drop of `sTready`.
- R4: A `stepPulse` sampled at a clock edge while the block is idle starts a burst. `mTvalid` is high for exactly `XFER_WORDS` consecutive cycles, starting two edges after the sampled pulse. `mTlast` is 1 only on the final beat.
- R5: The burst carries the words of the closed segments in the order they were written, oldest segment first.
- R6: If the closed segments hold fewer than `XFER_WORDS` words, the remaining beats carry `mTdata`=0.
- R7: The segment being written when a step is sampled is not drained. Its words appear in the burst of a later step, after the segment has closed.
- R8: `wordCountValid` pulses for one cycle together with the final beat. `wordCount` then equals the total number of words in the segments that step released. This count may exceed `XFER_WORDS`, in which case the words beyond the burst length are discarded.
- R9: If a segment closes while the other `NUM_SEGS`-1 segments are all closed and unread, the oldest unread segment is discarded. `overflowFlag` then goes to 1 and stays at 1 until reset.
- R10: A `stepPulse` sampled while a burst is in progress starts no further burst. It sets `stepErrFlag`, which stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sTdata | input | 32 | Incoming stream data |
| sTvalid | input | 1 | Incoming beat valid |
| sTlast | input | 1 | Incoming end-of-packet marker |
| sTready | output | 1 | Ready toward the producer (backpressure) |
| stepPulse | input | 1 | Periodic drain request |
| mTdata | output | 32 | Outgoing burst data (zero on padding beats) |
| mTvalid | output | 1 | Outgoing beat valid |
| mTlast | output | 1 | Final beat of the burst |
| wordCount | output | 32 | Valid words drained by the last step |
| wordCountValid | output | 1 | One-cycle strobe that qualifies `wordCount` |
| overflowFlag | output | 1 | Sticky: unread data was overwritten |
| stepErrFlag | output | 1 | Sticky: step pulse arrived during a burst |

## Verification
The main path is driven through a table of packet layouts, each followed by a step:
- A short single packet isolates zero padding.
- Two packets with an open tail separate closed segments from the open one.
- A tail that is later closed by a one-beat packet shows that open words survive a step.
- Packets ending exactly on the segment boundary show that a fill and a packet end coinciding close only one segment.
- An oversize packet splits across segments and yields a count above the burst length.
- An empty step yields an all-zero burst with a zero count.

Directed runs then close more segments than the ring holds, to expose the oldest-first drop, and inject a second step mid-burst.

// File: rtl/seg_ring_pkg.sv
package seg_ring_pkg;

  // Per-cycle strobes from the control unit to the datapath
  typedef struct packed {
    logic wrEn;    // store the accepted input beat
    logic rdEmit;  // produce one output beat this cycle
    logic rdPad;   // the beat is padding (data forced to zero)
    logic rdLast;  // the beat is the final one of the burst
  } ringStrobe_t;

  typedef enum logic {
    RD_IDLE  = 1'b0,
    RD_BURST = 1'b1
  } rdState_t;

endpackage

// File: rtl/seg_ring_ctrl.sv
module seg_ring_ctrl
  import seg_ring_pkg::*;
#(
  parameter int NUM_SEGS   = 15,
  parameter int SEG_DEPTH  = 8,
  parameter int XFER_WORDS = 10,
  parameter int ADDR_W     = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sValid,
  input  logic              sLast,
  output logic              sReady,
  input  logic              step,
  output ringStrobe_t       strb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [31:0]       snapCount,
  output logic              ovfFlag,
  output logic              stepErr
);

  localparam int SEG_W  = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1;
  localparam int LEN_W  = $clog2(SEG_DEPTH + 1);
  localparam int CC_W   = $clog2(NUM_SEGS + 1);
  localparam int BEAT_W = $clog2(XFER_WORDS + 1);

  function automatic logic [SEG_W-1:0] nextSeg(input logic [SEG_W-1:0] s);
    return (s == SEG_W'(NUM_SEGS - 1)) ? '0 : s + 1'b1;
  endfunction

  // ---------------- write side ----------------
  logic [SEG_W-1:0] wrSeg;
  logic [LEN_W-1:0] wrCnt;
  logic             pending;     // segment switch being committed
  logic [LEN_W-1:0] closeLen;
  logic [LEN_W-1:0] segLen [NUM_SEGS];

  logic             accept;
  logic [LEN_W-1:0] wrCntInc;
  logic             closeNow;

  assign sReady   = !rst && !pending;
  assign accept   = sValid && sReady;
  assign wrCntInc = wrCnt + 1'b1;
  assign closeNow = accept && (sLast || (wrCntInc == LEN_W'(SEG_DEPTH)));

  always_ff @(posedge clk) begin
    if (rst) begin
      wrSeg    <= '0;
      wrCnt    <= '0;
      pending  <= 1'b0;
      closeLen <= '0;
      for (int i = 0; i < NUM_SEGS; i++) segLen[i] <= '0;
    end else begin
      pending <= closeNow;
      if (accept) begin
        segLen[wrSeg] <= wrCntInc;
        wrCnt         <= wrCntInc;
      end
      if (closeNow) closeLen <= wrCntInc;
      if (pending) begin
        wrSeg <= nextSeg(wrSeg);
        wrCnt <= '0;
      end
    end
  end

  // ---------------- ring occupancy ----------------
  logic [SEG_W-1:0] rdSeg, rdSegN;
  logic [CC_W-1:0]  closedCnt, ccN;
  logic [31:0]      closedWords, cwN;
  logic             dropNow;
  rdState_t         state;
  logic             stepAcc, stepBusy;

  assign stepAcc  = step && (state == RD_IDLE);
  assign stepBusy = step && (state == RD_BURST);

  // Release on step first, then account for a segment committed this cycle
  always_comb begin
    rdSegN  = rdSeg;
    ccN     = closedCnt;
    cwN     = closedWords;
    dropNow = 1'b0;
    if (stepAcc) begin
      rdSegN = wrSeg;
      ccN    = '0;
      cwN    = '0;
    end
    if (pending) begin
      if (ccN == CC_W'(NUM_SEGS - 1)) begin
        dropNow = 1'b1;
        cwN     = cwN - 32'(segLen[rdSegN]);
        rdSegN  = nextSeg(rdSegN);
      end else begin
        ccN = ccN + 1'b1;
      end
      cwN = cwN + 32'(closeLen);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdSeg       <= '0;
      closedCnt   <= '0;
      closedWords <= '0;
      ovfFlag     <= 1'b0;
      stepErr     <= 1'b0;
    end else begin
      rdSeg       <= rdSegN;
      closedCnt   <= ccN;
      closedWords <= cwN;
      ovfFlag     <= ovfFlag | dropNow;
      stepErr     <= stepErr | stepBusy;
    end
  end

  // ---------------- readout burst ----------------
  logic [SEG_W-1:0]  bSeg;
  logic [LEN_W-1:0]  bIdx;
  logic [BEAT_W-1:0] emitLeft;
  logic [BEAT_W-1:0] beatNo;
  logic [LEN_W-1:0]  bIdxInc;
  logic              lastBeat;

  assign bIdxInc  = bIdx + 1'b1;
  assign lastBeat = (beatNo == BEAT_W'(XFER_WORDS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= RD_IDLE;
      bSeg      <= '0;
      bIdx      <= '0;
      emitLeft  <= '0;
      beatNo    <= '0;
      snapCount <= '0;
    end else begin
      case (state)
        RD_IDLE: begin
          if (step) begin
            state     <= RD_BURST;
            bSeg      <= rdSeg;
            bIdx      <= '0;
            beatNo    <= '0;
            snapCount <= closedWords;
            emitLeft  <= (closedWords < 32'(XFER_WORDS)) ? BEAT_W'(closedWords)
                                                        : BEAT_W'(XFER_WORDS);
          end
        end
        RD_BURST: begin
          beatNo <= beatNo + 1'b1;
          if (emitLeft != '0) begin
            emitLeft <= emitLeft - 1'b1;
            if (bIdxInc >= segLen[bSeg]) begin
              bSeg <= nextSeg(bSeg);
              bIdx <= '0;
            end else begin
              bIdx <= bIdxInc;
            end
          end
          if (lastBeat) state <= RD_IDLE;
        end
        default: state <= RD_IDLE;
      endcase
    end
  end

  // ---------------- strobes and addresses ----------------
  always_comb begin
    strb.wrEn   = accept;
    strb.rdEmit = (state == RD_BURST);
    strb.rdPad  = (emitLeft == '0);
    strb.rdLast = lastBeat;
  end

  assign wrAddr = ADDR_W'(wrSeg) * ADDR_W'(SEG_DEPTH) + ADDR_W'(wrCnt);
  assign rdAddr = ADDR_W'(bSeg) * ADDR_W'(SEG_DEPTH) + ADDR_W'(bIdx);

endmodule

// File: rtl/seg_ring_dpath.sv
module seg_ring_dpath
  import seg_ring_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_SEGS  = 15,
  parameter int SEG_DEPTH = 8,
  parameter int ADDR_W    = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  ringStrobe_t       strb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] inData,
  input  logic [31:0]       snapCount,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  output logic              outLast,
  output logic [31:0]       cntOut,
  output logic              cntValid
);

  localparam int MEM_WORDS = NUM_SEGS * SEG_DEPTH;

  logic [DATA_W-1:0] ringMem [MEM_WORDS];

  always_ff @(posedge clk) begin
    if (strb.wrEn) ringMem[wrAddr] <= inData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outData  <= '0;
      outValid <= 1'b0;
      outLast  <= 1'b0;
      cntOut   <= '0;
      cntValid <= 1'b0;
    end else begin
      outValid <= strb.rdEmit;
      outLast  <= strb.rdEmit && strb.rdLast;
      cntValid <= strb.rdEmit && strb.rdLast;
      outData  <= (strb.rdEmit && !strb.rdPad) ? ringMem[rdAddr] : '0;
      if (strb.rdEmit && strb.rdLast) cntOut <= snapCount;
    end
  end

endmodule

// File: rtl/seg_ring_capture.sv
module seg_ring_capture
  import seg_ring_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int NUM_SEGS   = 15,
  parameter int SEG_DEPTH  = 8,
  parameter int XFER_WORDS = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] sTdata,
  input  logic              sTvalid,
  input  logic              sTlast,
  output logic              sTready,
  input  logic              stepPulse,
  output logic [DATA_W-1:0] mTdata,
  output logic              mTvalid,
  output logic              mTlast,
  output logic [31:0]       wordCount,
  output logic              wordCountValid,
  output logic              overflowFlag,
  output logic              stepErrFlag
);

  localparam int ADDR_W = $clog2(NUM_SEGS * SEG_DEPTH);

  ringStrobe_t       strb;
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  logic [31:0]       snapCount;

  seg_ring_ctrl #(
    .NUM_SEGS(NUM_SEGS), .SEG_DEPTH(SEG_DEPTH),
    .XFER_WORDS(XFER_WORDS), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .sValid(sTvalid), .sLast(sTlast), .sReady(sTready),
    .step(stepPulse), .strb(strb),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .snapCount(snapCount),
    .ovfFlag(overflowFlag), .stepErr(stepErrFlag)
  );

  seg_ring_dpath #(
    .DATA_W(DATA_W), .NUM_SEGS(NUM_SEGS),
    .SEG_DEPTH(SEG_DEPTH), .ADDR_W(ADDR_W)
  ) u_dpath (
    .clk(clk), .rst(rst), .strb(strb),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .inData(sTdata),
    .snapCount(snapCount),
    .outData(mTdata), .outValid(mTvalid), .outLast(mTlast),
    .cntOut(wordCount), .cntValid(wordCountValid)
  );

endmodule

// File: rtl/seg_ring_checker.sv
module seg_ring_checker #(
  parameter int XFER_WORDS = 10
) (
  input logic clk,
  input logic rst,
  input logic sTvalid,
  input logic sTlast,
  input logic sTready,
  input logic mTvalid,
  input logic mTlast,
  input logic wordCountValid,
  input logic overflowFlag,
  input logic stepErrFlag
);

  int beatRun;

  always_ff @(posedge clk) begin
    if (rst) beatRun <= 0;
    else if (mTvalid && !mTlast) beatRun <= beatRun + 1;
    else beatRun <= 0;
  end

  p_ready_low_in_reset_r1: assert property (@(posedge clk) rst |-> !sTready);

  p_gap_after_last_r2: assert property (@(posedge clk) disable iff (rst)
    (sTvalid && sTready && sTlast) |=> !sTready);

  p_gap_single_cycle_r3: assert property (@(posedge clk) disable iff (rst)
    !sTready |=> sTready);

  p_last_within_burst_r4: assert property (@(posedge clk) disable iff (rst)
    mTlast |-> mTvalid);

  p_burst_contiguous_r4: assert property (@(posedge clk) disable iff (rst)
    (mTvalid && !mTlast) |=> mTvalid);

  p_burst_length_r4: assert property (@(posedge clk) disable iff (rst)
    mTlast |-> (beatRun == XFER_WORDS - 1));

  p_count_with_last_r8: assert property (@(posedge clk) disable iff (rst)
    wordCountValid |-> (mTvalid && mTlast));

  p_last_has_count_r8: assert property (@(posedge clk) disable iff (rst)
    mTlast |-> wordCountValid);

  p_overflow_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    overflowFlag |=> overflowFlag);

  p_step_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    stepErrFlag |=> stepErrFlag);

endmodule

bind seg_ring_capture seg_ring_checker #(.XFER_WORDS(XFER_WORDS)) u_chk (
  .clk(clk), .rst(rst), .sTvalid(sTvalid), .sTlast(sTlast), .sTready(sTready),
  .mTvalid(mTvalid), .mTlast(mTlast), .wordCountValid(wordCountValid),
  .overflowFlag(overflowFlag), .stepErrFlag(stepErrFlag)
);

// File: tb/sim_seg_ring_capture.sv
`timescale 1ns/1ps
module sim_seg_ring_capture;

  localparam int NSEG  = 15;
  localparam int DEPTH = 8;
  localparam int NXFER = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] sTdata = '0;
  logic        sTvalid = 1'b0, sTlast = 1'b0, stepPulse = 1'b0;
  logic        sTready, mTvalid, mTlast, wordCountValid, overflowFlag, stepErrFlag;
  logic [31:0] mTdata, wordCount;

  always #10 clk = ~clk;

  seg_ring_capture #(.DATA_W(32), .NUM_SEGS(NSEG), .SEG_DEPTH(DEPTH), .XFER_WORDS(NXFER)) u0 (
    .clk(clk), .rst(rst), .sTdata(sTdata), .sTvalid(sTvalid), .sTlast(sTlast),
    .sTready(sTready), .stepPulse(stepPulse), .mTdata(mTdata), .mTvalid(mTvalid),
    .mTlast(mTlast), .wordCount(wordCount), .wordCountValid(wordCountValid),
    .overflowFlag(overflowFlag), .stepErrFlag(stepErrFlag)
  );

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;

  // Reference model of ring contents
  logic [31:0] closedData[$];
  int          closedLens[$];
  logic [31:0] openData[$];
  bit          ovfExp = 1'b0;
  logic [31:0] seed = 32'h1000;

  // Packet layouts per table row: up to four packets, then an open tail
  localparam int ROWS = 6;
  localparam int PKTS [ROWS][4] = '{
    '{3, 0, 0, 0},
    '{4, 5, 0, 0},
    '{1, 0, 0, 0},
    '{8, 8, 0, 0},
    '{12, 0, 0, 0},
    '{0, 0, 0, 0}
  };
  localparam int TAIL [ROWS] = '{0, 2, 0, 0, 3, 0};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  task automatic modelClose();
    if (closedLens.size() == NSEG - 1) begin
      int d;
      d = closedLens.pop_front();
      repeat (d) void'(closedData.pop_front());
      ovfExp = 1'b1;
    end
    foreach (openData[i]) closedData.push_back(openData[i]);
    closedLens.push_back(openData.size());
    openData.delete();
  endtask

  task automatic pushBeat(input logic [31:0] d, input bit last);
    bit closes;
    @(negedge clk);
    sTdata = d; sTlast = last; sTvalid = 1'b1;
    while (!sTready) @(negedge clk);
    @(negedge clk);
    sTvalid = 1'b0; sTlast = 1'b0;
    closes = last || (openData.size() + 1 == DEPTH);
    if (last) chk(sTready == !closes, "R2 ready gap", 32'(sTready), 32'(!closes));
    else      chk(sTready == !closes, "R3 ready gap", 32'(sTready), 32'(!closes));
    openData.push_back(d);
    if (closes) modelClose();
  endtask

  task automatic sendPacket(input int len, input bit withLast);
    for (int i = 0; i < len; i++) begin
      pushBeat(seed, withLast && (i == len - 1));
      seed = seed + 1;
    end
  endtask

  // Step and check the whole burst; injectAt >= 0 raises a second step mid-burst
  task automatic doStep(input int injectAt);
    int          expCount;
    logic [31:0] expData;
    expCount = closedData.size();
    @(negedge clk); stepPulse = 1'b1;
    @(negedge clk); stepPulse = 1'b0;
    for (int k = 0; k < NXFER; k++) begin
      @(negedge clk);
      stepPulse = (k == injectAt);
      expData = (k < expCount) ? closedData[k] : 32'h0;
      chk(mTvalid == 1'b1, "R4 valid", 32'(mTvalid), 32'h1);
      chk(mTlast == (k == NXFER - 1), "R4 last", 32'(mTlast), 32'(k == NXFER - 1));
      if (k < expCount) chk(mTdata == expData, "R5 data order", mTdata, expData);
      else              chk(mTdata == 32'h0, "R6 zero pad", mTdata, 32'h0);
      if (k == NXFER - 1) begin
        chk(wordCountValid == 1'b1, "R8 count strobe", 32'(wordCountValid), 32'h1);
        chk(wordCount == 32'(expCount), "R8 R7 drained count", wordCount, 32'(expCount));
      end else begin
        chk(wordCountValid == 1'b0, "R8 early strobe", 32'(wordCountValid), 32'h0);
      end
    end
    stepPulse = 1'b0;
    @(negedge clk);
    chk(mTvalid == 1'b0, "R4 burst end", 32'(mTvalid), 32'h0);
    closedData.delete();
    closedLens.delete();
    chk(overflowFlag == ovfExp, "R9 overflow flag", 32'(overflowFlag), 32'(ovfExp));
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(sTready == 1'b0, "R1 ready in reset", 32'(sTready), 32'h0);
    chk(mTvalid == 1'b0 && mTlast == 1'b0, "R1 burst idle", 32'(mTvalid), 32'h0);
    chk(wordCount == 32'h0 && wordCountValid == 1'b0, "R1 count", wordCount, 32'h0);
    chk(overflowFlag == 1'b0 && stepErrFlag == 1'b0, "R1 flags", 32'({overflowFlag, stepErrFlag}), 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(sTready == 1'b1, "R1 ready after reset", 32'(sTready), 32'h1);

    // Table walk; row 3 closes the earlier open tail (R7), row 6 drains nothing while words stay open (R7)
    for (int r = 0; r < ROWS; r++) begin
      for (int p = 0; p < 4; p++) if (PKTS[r][p] > 0) sendPacket(PKTS[r][p], 1'b1);
      sendPacket(TAIL[r], 1'b0);
      doStep(-1);
    end

    // R9: close more segments than the ring can hold without stepping
    chk(overflowFlag == 1'b0, "R9 no overflow yet", 32'(overflowFlag), 32'h0);
    for (int i = 0; i < NSEG + 1; i++) sendPacket(2, 1'b1);
    @(negedge clk);
    chk(overflowFlag == 1'b1, "R9 overflow raised", 32'(overflowFlag), 32'h1);
    doStep(-1);

    // R10: second step during a burst
    sendPacket(4, 1'b1);
    chk(stepErrFlag == 1'b0, "R10 no error yet", 32'(stepErrFlag), 32'h0);
    doStep(3);
    for (int i = 0; i < NXFER + 3; i++) begin
      chk(mTvalid == 1'b0, "R10 no extra burst", 32'(mTvalid), 32'h0);
      @(negedge clk);
    end
    chk(stepErrFlag == 1'b1, "R10 error flag", 32'(stepErrFlag), 32'h1);

    finish();
  end

endmodule